// File: doc/BRIEF.md
# Conversion Word Calibration Corrector

This block sits between a converter's decimation filter and its data register. Every raw 24-bit filter word that arrives with a valid strobe is corrected in two steps. First a signed offset coefficient is removed. Then the difference is scaled by an unsigned span coefficient. The corrected value is clamped to the output range and formatted as an unsigned or offset-binary word of 16 or 24 bits. The result leaves exactly two clock cycles after it entered.

The two 24-bit coefficients are held in the block. A host can read and write them through a small register port: one select bit, a write strobe, write data and a combinational read-back. A calibration sequencer can load the same registers through that port. Because the offset is removed ahead of the multiplication, the span coefficient is a pure gain and does not interact with the zero point. The span coefficient is fixed-point with 0x400000 meaning unity. The product is shifted right by 22 with floor rounding, and the shifted value is held in a 33-bit signed intermediate before clamping.

The coding mode (`raw_bipolar`) and the output width (`raw_wide`) are sampled together with each word. A mode change therefore never corrupts a word that is already in flight.

The pipeline has no state machine. Each of its two stages is a register bank whose contents advance whenever a valid word enters or leaves.

Top module: `cal_correct`

## Requirements
- R1: After reset `out_valid` is 0, the offset register (select 0) reads 0x000000 and the span register (select 1) reads 0x400000.
- R2: When `cfg_wr` is high at a clock edge, `cfg_wdata` is stored into the register chosen by `cfg_sel` (0 = offset, 1 = span). Neither register changes without a write, and `cfg_rdata` always shows the selected register.
- R3: `out_valid` is high in exactly those cycles that come two clock edges after a cycle with `raw_valid` high.
- R4: The correction computes floor((x − offset) × span / 2^22). Here offset is read as a signed 24-bit value and x is the signed input value, so the offset is removed before the span is applied.
- R5: With `raw_bipolar` = 1 the input and output are offset binary with zero at 0x800000: x = raw − 0x800000, and 0x800000 is added back after scaling.
- R6: With `raw_bipolar` = 0 the input is unsigned (x = raw) and the output is unsigned.
- R7: A corrected 24-bit value below 0 becomes 0x000000 and a value above 0xFFFFFF becomes 0xFFFFFF. In 16-bit mode the result clips at 0xFFFF.
- R8: With `raw_wide` = 0 the output is (v + 0x80) >> 8, where v is the clamped 24-bit value. This rounds to nearest. The result sits in `out_data[15:0]` and `out_data[23:16]` is 0.
- R9: The coding and width mode of a word are those present with its `raw_valid`. Changes on the following cycles do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Coefficient write strobe |
| cfg_sel | input | 1 | Register select: 0 offset, 1 span |
| cfg_wdata | input | 24 | Coefficient write data |
| cfg_rdata | output | 24 | Selected coefficient read-back |
| raw_valid | input | 1 | Raw word valid |
| raw_data | input | 24 | Raw filter word |
| raw_bipolar | input | 1 | 1 = offset-binary coding, 0 = unipolar |
| raw_wide | input | 1 | 1 = 24-bit output, 0 = 16-bit output |
| out_valid | output | 1 | Corrected word valid |
| out_data | output | 24 | Corrected word (16-bit results in bits 15:0) |

## Verification
- **Coefficient faults.** A wrong offset or span register shows on `cfg_rdata` in the same cycle it is selected. It shows on `out_data` in the first corrected word, two cycles after entry.
- **Pipeline faults.** A lost or extra valid bit shows on `out_valid` at the cycle it leaves stage two.
- **Mode faults.** A mode bit that is not carried with its word shows only when the mode changes while that word is in flight. The stimulus therefore flips the mode on every word.
- **Clamping and rounding faults.** These show only on inputs near the rails or near half-LSB boundaries. Those cases are driven directly rather than left to chance.

// File: rtl/cal_pkg.sv
package cal_pkg;
    localparam int RAW_W    = 24;
    localparam int COEF_W   = 24;
    localparam int FRAC_W   = 22;
    localparam int ACC_W    = 33;
    localparam int NARROW_W = 16;
    localparam int DIFF_W   = RAW_W + 2;
    localparam int PROD_W   = DIFF_W + COEF_W + 1;
    localparam logic [COEF_W-1:0] SPAN_ONE = COEF_W'(1) << FRAC_W;
    localparam logic [RAW_W-1:0]  MID_CODE = RAW_W'(1) << (RAW_W - 1);

    typedef enum logic {
        SEL_OFFSET = 1'b0,
        SEL_SPAN   = 1'b1
    } coef_sel_e;

    typedef struct packed {
        logic                     vld;
        logic                     bip;
        logic                     wide;
        logic signed [DIFF_W-1:0] diff;
    } stage1_t;
endpackage

// File: rtl/cal_coef_regs.sv
module cal_coef_regs
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [COEF_W-1:0] wdata,
    output logic [COEF_W-1:0] rdata,
    output logic [COEF_W-1:0] offset_q,
    output logic [COEF_W-1:0] span_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offset_q <= '0;
            span_q   <= SPAN_ONE;
        end else if (wr) begin
            unique case (coef_sel_e'(sel))
                SEL_OFFSET: offset_q <= wdata;
                SEL_SPAN:   span_q   <= wdata;
            endcase
        end
    end

    always_comb begin
        unique case (coef_sel_e'(sel))
            SEL_OFFSET: rdata = offset_q;
            SEL_SPAN:   rdata = span_q;
        endcase
    end

    // R2
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> ($stable(offset_q) && $stable(span_q)));

    // R2
    span_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel) |=> (span_q == $past(wdata)));

    // R2
    offset_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !sel) |=> (offset_q == $past(wdata)));
endmodule

// File: rtl/cal_offset_stage.sv
module cal_offset_stage
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_data,
    input  logic              in_bip,
    input  logic              in_wide,
    input  logic [COEF_W-1:0] offset,
    output stage1_t           q
);
    logic signed [RAW_W:0]    x_s;
    logic signed [DIFF_W-1:0] diff_d;

    always_comb begin
        if (in_bip) x_s = $signed({1'b0, in_data} - {1'b0, MID_CODE});
        else        x_s = $signed({1'b0, in_data});
        diff_d = $signed({x_s[RAW_W], x_s})
               - $signed({{(DIFF_W-COEF_W){offset[COEF_W-1]}}, offset});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) begin
                q.bip  <= in_bip;
                q.wide <= in_wide;
                q.diff <= diff_d;
            end
        end
    end
endmodule

// File: rtl/cal_scale_stage.sv
module cal_scale_stage
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  stage1_t           s1,
    input  logic [COEF_W-1:0] span,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_data
);
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc;
    logic signed [ACC_W-1:0]  biased;
    logic [RAW_W-1:0]         clamped;
    logic [RAW_W:0]           rounded;
    logic [RAW_W-1:0]         fmt_d;

    always_comb begin
        prod   = PROD_W'(s1.diff) * $signed({1'b0, span});
        acc    = ACC_W'(prod >>> FRAC_W);
        biased = s1.bip ? acc + $signed({{(ACC_W-RAW_W){1'b0}}, MID_CODE}) : acc;
        if (biased[ACC_W-1])
            clamped = '0;
        else if (|biased[ACC_W-2:RAW_W])
            clamped = '1;
        else
            clamped = biased[RAW_W-1:0];
        rounded = {1'b0, clamped} + (RAW_W+1)'(1 << (RAW_W - NARROW_W - 1));
        if (s1.wide)
            fmt_d = clamped;
        else if (rounded[RAW_W])
            fmt_d = RAW_W'({NARROW_W{1'b1}});
        else
            fmt_d = RAW_W'(rounded[RAW_W-1:RAW_W-NARROW_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1.vld;
            if (s1.vld) out_data <= fmt_d;
        end
    end

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1.vld && !s1.wide) |=> (out_data[RAW_W-1:NARROW_W] == '0));
endmodule

// File: rtl/cal_correct.sv
module cal_correct
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [COEF_W-1:0] cfg_wdata,
    output logic [COEF_W-1:0] cfg_rdata,
    input  logic              raw_valid,
    input  logic [RAW_W-1:0]  raw_data,
    input  logic              raw_bipolar,
    input  logic              raw_wide,
    output logic              out_valid,
    output logic [RAW_W-1:0]  out_data
);
    logic [COEF_W-1:0] offset_q;
    logic [COEF_W-1:0] span_q;
    stage1_t           s1;

    cal_coef_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .offset_q (offset_q),
        .span_q   (span_q)
    );

    cal_offset_stage u_off (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (raw_valid),
        .in_data  (raw_data),
        .in_bip   (raw_bipolar),
        .in_wide  (raw_wide),
        .offset   (offset_q),
        .q        (s1)
    );

    cal_scale_stage u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1        (s1),
        .span      (span_q),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // R3
    latency_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(raw_valid, 2));

    // R3
    latency_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> ##2 out_valid);
endmodule

// File: tb/cal_correct_test.sv
module cal_correct_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [23:0] cfg_wdata = '0;
    logic [23:0] cfg_rdata;
    logic        raw_valid = 1'b0;
    logic [23:0] raw_data = '0;
    logic        raw_bipolar = 1'b0;
    logic        raw_wide = 1'b1;
    logic        out_valid;
    logic [23:0] out_data;

    int checks = 0;
    int fails = 0;
    logic [23:0] cur_off = 24'h000000;
    logic [23:0] cur_span = 24'h400000;
    logic        ev1 = 1'b0, ev2 = 1'b0;
    logic [23:0] ed1 = '0, ed2 = '0;
    string       et1 = "", et2 = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    cal_correct uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .raw_valid(raw_valid), .raw_data(raw_data), .raw_bipolar(raw_bipolar), .raw_wide(raw_wide),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [23:0] model(input logic [23:0] raw, input logic [23:0] off,
                                          input logic [23:0] span, input logic bip, input logic wide);
        longint x, d, p;
        x = bip ? longint'(raw) - 64'sh800000 : longint'(raw);
        d = x - longint'($signed(off));
        p = (d * longint'(span)) >>> 22;
        if (bip) p = p + 64'sh800000;
        if (p < 0) p = 0;
        if (p > 64'shFFFFFF) p = 64'shFFFFFF;
        if (!wide) begin
            p = (p + 128) >>> 8;
            if (p > 64'shFFFF) p = 64'shFFFF;
        end
        return p[23:0];
    endfunction

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [23:0] d, input logic b, input logic w, input string tag);
        @(negedge clk);
        check({"R3 valid ", et2}, {23'b0, out_valid}, {23'b0, ev2});
        if (ev2) check(et2, out_data, ed2);
        ev2 = ev1; ed2 = ed1; et2 = et1;
        ev1 = v; ed1 = model(d, cur_off, cur_span, b, w); et1 = tag;
        raw_valid = v; raw_data = d; raw_bipolar = b; raw_wide = w;
        cfg_wr = 1'b0;
    endtask

    task automatic drain();
        repeat (3) step(1'b0, '0, 1'b0, 1'b1, "R3 idle");
    endtask

    task automatic write_coef(input logic sel, input logic [23:0] val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel) cur_span = val; else cur_off = val;
        #1 check("R2 readback", cfg_rdata, val);
    endtask

    task automatic read_coef(input logic sel, input logic [23:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel;
        #1 check(tag, cfg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        #1 check("R1 out_valid reset", {23'b0, out_valid}, 24'h0);
        read_coef(1'b0, 24'h000000, "R1 offset reset");
        read_coef(1'b1, 24'h400000, "R1 span reset");
        rst_n = 1'b1;

        // R5 unity bipolar: mid code stays mid code
        step(1'b1, 24'h800000, 1'b1, 1'b1, "R5 bipolar zero");
        step(1'b1, 24'h812345, 1'b1, 1'b1, "R5 bipolar positive");
        step(1'b1, 24'h123456, 1'b0, 1'b1, "R6 unipolar identity");
        // R8 rounding and narrow clip
        step(1'b1, 24'h123480, 1'b0, 1'b0, "R8 round up");
        step(1'b1, 24'h12347F, 1'b0, 1'b0, "R8 round down");
        step(1'b1, 24'hFFFFF0, 1'b0, 1'b0, "R7 narrow clip");
        drain();

        // R2 host writes; R9 cannot be observed yet, R4 order check next
        write_coef(1'b0, 24'h000100);
        read_coef(1'b1, 24'h400000, "R2 span untouched");
        step(1'b1, 24'h000010, 1'b0, 1'b1, "R7 low clamp");
        step(1'b1, 24'h000300, 1'b0, 1'b1, "R4 offset only");
        drain();
        write_coef(1'b1, 24'h800000);
        read_coef(1'b0, 24'h000100, "R2 offset untouched");
        step(1'b1, 24'h000300, 1'b0, 1'b1, "R4 offset then gain");
        step(1'b1, 24'hF00000, 1'b0, 1'b1, "R7 high clamp");
        step(1'b1, 24'h000000, 1'b1, 1'b1, "R7 bipolar low clamp");
        drain();
        write_coef(1'b0, 24'hFFFF00);
        step(1'b1, 24'h800000, 1'b1, 1'b1, "R4 negative offset");
        drain();

        // R9 mode flips every word while earlier words are in flight
        for (int i = 0; i < 8; i++)
            step(1'b1, 24'h7FFF00 + 24'(i * 24'h000123), 1'(i), 1'(i >> 1), "R9 mode flip");
        drain();

        // R3 R4 R5 R6 R7 R8 random batches
        for (int b = 0; b < 20; b++) begin
            write_coef(1'b0, 24'($urandom) >> ($urandom % 12));
            write_coef(1'b1, 24'($urandom) >> ($urandom % 4));
            for (int i = 0; i < 40; i++) begin
                logic [23:0] d;
                d = 24'($urandom);
                if ($urandom % 8 == 0) d = ($urandom % 2 == 1) ? 24'hFFFFFF : 24'h000000;
                step(1'($urandom % 4 != 0), d, 1'($urandom), 1'($urandom), "R4 random");
            end
            drain();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule